// File: doc/BRIEF.md
# Dual-Conversion Sampling Sequencer Register

This block holds an 8-bit control and status register for a single-shot analog-to-digital conversion, together with the small sequencer that the register steers. A bus write stores an enable bit and a 4-bit secondary channel code. A start pulse launches a conversion on the primary channel given at the block's input. When paired sampling is in effect, the sequencer then chains a second conversion of equal length on the secondary channel. A read-only status bit reports that second phase.

The sample-and-hold stage and the converter core lie outside the block. The block drives a held conversion request and a channel number for a fixed, parameterised number of clock cycles per conversion. It pulses a done strobe after each conversion and a complete strobe after the whole sequence. Paired sampling takes effect only when three things hold: the stored enable is 1, the sample-and-hold mode input from the companion mode register is high, and the channel code names one of channels 12 to 15. An enable that meets a code outside that range sets a sticky error flag, and only the first conversion runs.

Top module: `dss_seq_top`

## Requirements
- R1: After a synchronous reset the register reads 8'h00, `conv_req_o`, `conv_done_o`, `seq_done_o` and `sel_err_o` are 0.
- R2: Register layout: bit 0 is the stored enable and bits 7:4 the secondary channel code, both written by `wr_en_i` and read back on `rd_data_o`. Bits 3:2 always read 0 whatever is written. Bit 1 is read-only status, and a write does not change it.
- R3: A start pulse seen while idle raises `conv_req_o` on the next cycle for exactly `CONV_CYCLES` cycles, with `conv_ch_o` equal to `prim_ch_i` as sampled at the start. A start pulse seen while a sequence runs is ignored.
- R4: `conv_done_o` is high for one cycle right after each conversion ends. `seq_done_o` is high for one cycle right after the last conversion of the sequence ends.
- R5: If enable=1, `sh_mode_i`=1 and the code is 4'b1100 to 4'b1111 at the start, a second conversion of exactly `CONV_CYCLES` cycles follows the first with no gap, with `conv_ch_o` equal to the code (channel 12 to 15).
- R6: Register bit 1 reads 1 exactly during the cycles of the second conversion, and 0 at all other times.
- R7: With `sh_mode_i`=0 at the start, only the first conversion runs and `sel_err_o` does not change, whatever the register holds.
- R8: With enable=1, `sh_mode_i`=1 and a code from 4'b0000 to 4'b1011 at the start, only the first conversion runs and `sel_err_o` becomes 1 from the next cycle and stays 1 until reset.
- R9: A write during a running sequence is visible on `rd_data_o` at once but does not change that sequence. A write in the same cycle as a start pulse is not used by that start.
- R10: With enable=0 at the start, only the first conversion runs and no error is raised, whatever the channel code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data, including status |
| sh_mode_i | input | 1 | Sample-and-hold mode from the companion mode register |
| prim_ch_i | input | 4 | Primary channel for the first conversion |
| start_i | input | 1 | Start pulse |
| conv_req_o | output | 1 | Conversion request to the converter core |
| conv_ch_o | output | 4 | Channel of the running conversion |
| conv_done_o | output | 1 | One-cycle strobe after each conversion |
| seq_done_o | output | 1 | One-cycle strobe after the whole sequence |
| sel_err_o | output | 1 | Sticky flag for enable with an illegal channel code |

## Verification
Random register values, mode levels and primary channels are mixed. Each start therefore falls into one of four cases: a legal pair, a disabled enable, a masked mode, or an illegal code. These cases separate the one-conversion paths from the two-conversion path, and the erroring single run from the clean one. A cycle-by-cycle model checks request, channel, status, done and complete strobes against the run length. This catches off-by-one counts and any gap between the two phases. Directed runs write the register and pulse start in the middle of a sequence. They also cover a write in the same cycle as a start and the boundary codes 4'b1011 and 4'b1100, and they confirm that the error flag stays set across later clean runs.

// File: rtl/dss_pkg.sv
package dss_pkg;

    localparam int REG_W   = 8;
    localparam int CH_W    = 4;
    localparam int EN_BIT  = 0;
    localparam int ST_BIT  = 1;
    localparam int SEL_LSB = 4;

    // stored part of the register
    typedef struct packed {
        logic [CH_W-1:0] sel;
        logic            en;
    } cfg_t;

    // snapshot taken at start
    typedef struct packed {
        logic            dual;
        logic            bad;
        logic [CH_W-1:0] prim;
        logic [CH_W-1:0] sec;
    } plan_t;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FIRST  = 2'd1,
        PH_SECOND = 2'd2
    } phase_t;

    // codes 12..15 are the only legal paired channels
    function automatic logic sel_pair_ok(input logic [CH_W-1:0] s);
        return s[CH_W-1] & s[CH_W-2];
    endfunction

    function automatic logic [REG_W-1:0] pack_reg(input cfg_t c, input logic st);
        logic [REG_W-1:0] r;
        r                        = '0;
        r[EN_BIT]                = c.en;
        r[ST_BIT]                = st;
        r[SEL_LSB +: CH_W]       = c.sel;
        return r;
    endfunction

    function automatic cfg_t unpack_reg(input logic [REG_W-1:0] d);
        cfg_t c;
        c.en  = d[EN_BIT];
        c.sel = d[SEL_LSB +: CH_W];
        return c;
    endfunction

endpackage

// File: rtl/dss_cfg_reg.sv
module dss_cfg_reg
    import dss_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    output cfg_t             cfg_o
);

    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en_i) begin
            cfg_q <= unpack_reg(wr_data_i);
        end
    end

    assign cfg_o = cfg_q;

    // R2: stored fields only move on a write
    p_hold_without_write_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_en_i |=> $stable(cfg_q));

endmodule

// File: rtl/dss_plan_dec.sv
module dss_plan_dec
    import dss_pkg::*;
(
    input  cfg_t            cfg_i,
    input  logic            sh_mode_i,
    input  logic [CH_W-1:0] prim_ch_i,
    output plan_t           plan_o
);

    logic eff_en;
    logic code_ok;

    always_comb begin
        eff_en       = cfg_i.en & sh_mode_i;   // enable masked by sample-and-hold mode
        code_ok      = sel_pair_ok(cfg_i.sel);
        plan_o.dual  = eff_en & code_ok;
        plan_o.bad   = eff_en & ~code_ok;
        plan_o.prim  = prim_ch_i;
        plan_o.sec   = cfg_i.sel;
    end

endmodule

// File: rtl/dss_seq_fsm.sv
module dss_seq_fsm
    import dss_pkg::*;
#(
    parameter int CONV_CYCLES = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  plan_t           plan_i,
    output logic            conv_req_o,
    output logic [CH_W-1:0] conv_ch_o,
    output logic            second_o,
    output logic            conv_done_o,
    output logic            seq_done_o,
    output logic            err_o
);

    localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CONV_CYCLES - 1);

    phase_t           phase_q;
    logic [CNT_W-1:0] cnt_q;
    plan_t            plan_q;
    logic             done_q;
    logic             fin_q;
    logic             err_q;
    logic             last_cyc;

    assign last_cyc = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            plan_q  <= '0;
            done_q  <= 1'b0;
            fin_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            fin_q  <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        plan_q  <= plan_i;
                        phase_q <= PH_FIRST;
                        cnt_q   <= CNT_LAST;
                        if (plan_i.bad) begin
                            err_q <= 1'b1;
                        end
                    end
                end
                PH_FIRST: begin
                    if (last_cyc) begin
                        done_q <= 1'b1;
                        if (plan_q.dual) begin
                            phase_q <= PH_SECOND;
                            cnt_q   <= CNT_LAST;
                        end else begin
                            phase_q <= PH_IDLE;
                            fin_q   <= 1'b1;
                        end
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_SECOND: begin
                    if (last_cyc) begin
                        done_q  <= 1'b1;
                        fin_q   <= 1'b1;
                        phase_q <= PH_IDLE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign conv_req_o  = (phase_q != PH_IDLE);
    assign second_o    = (phase_q == PH_SECOND);
    assign conv_ch_o   = second_o ? plan_q.sec : plan_q.prim;
    assign conv_done_o = done_q;
    assign seq_done_o  = fin_q;
    assign err_o       = err_q;

    // R3: a request only begins after a start pulse
    p_req_after_start_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(conv_req_o) |-> $past(start_i));

    // R4: the complete strobe closes a running sequence and coincides with a done strobe
    p_fin_closes_seq_r4: assert property (@(posedge clk) disable iff (rst)
        seq_done_o |-> ($past(conv_req_o) && conv_done_o));

    // R5: the second phase only ever addresses channels 12..15
    p_second_legal_ch_r5: assert property (@(posedge clk) disable iff (rst)
        second_o |-> (conv_ch_o[CH_W-1:CH_W-2] == 2'b11));

    // R6: the second phase starts right as the first one reports done
    p_second_follows_first_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(second_o) |-> conv_done_o);

    // R8: the error flag never clears outside reset
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);

endmodule

// File: rtl/dss_seq_top.sv
module dss_seq_top
    import dss_pkg::*;
#(
    parameter int CONV_CYCLES = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en_i,
    input  logic [7:0]   wr_data_i,
    output logic [7:0]   rd_data_o,
    input  logic         sh_mode_i,
    input  logic [3:0]   prim_ch_i,
    input  logic         start_i,
    output logic         conv_req_o,
    output logic [3:0]   conv_ch_o,
    output logic         conv_done_o,
    output logic         seq_done_o,
    output logic         sel_err_o
);

    cfg_t  cfg;
    plan_t plan;
    logic  second;

    dss_cfg_reg u_reg (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .cfg_o     (cfg)
    );

    dss_plan_dec u_dec (
        .cfg_i     (cfg),
        .sh_mode_i (sh_mode_i),
        .prim_ch_i (prim_ch_i),
        .plan_o    (plan)
    );

    dss_seq_fsm #(.CONV_CYCLES(CONV_CYCLES)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .plan_i      (plan),
        .conv_req_o  (conv_req_o),
        .conv_ch_o   (conv_ch_o),
        .second_o    (second),
        .conv_done_o (conv_done_o),
        .seq_done_o  (seq_done_o),
        .err_o       (sel_err_o)
    );

    assign rd_data_o = pack_reg(cfg, second);

    // R6: the status bit never shows outside a running request
    p_status_in_req_r6: assert property (@(posedge clk) disable iff (rst)
        rd_data_o[ST_BIT] |-> conv_req_o);

endmodule

// File: tb/tb_dss_seq_top.sv
module tb_dss_seq_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCYC       = 5;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en_i;
    logic [7:0] wr_data_i;
    logic [7:0] rd_data_o;
    logic       sh_mode_i;
    logic [3:0] prim_ch_i;
    logic       start_i;
    logic       conv_req_o;
    logic [3:0] conv_ch_o;
    logic       conv_done_o;
    logic       seq_done_o;
    logic       sel_err_o;

    int checks   = 0;
    int failures = 0;

    // bench-side model of the register and error flag
    logic       m_en;
    logic [3:0] m_sel;
    logic       m_err;

    dss_seq_top #(.CONV_CYCLES(NCYC)) dut (
        .clk         (clk),
        .rst         (rst),
        .wr_en_i     (wr_en_i),
        .wr_data_i   (wr_data_i),
        .rd_data_o   (rd_data_o),
        .sh_mode_i   (sh_mode_i),
        .prim_ch_i   (prim_ch_i),
        .start_i     (start_i),
        .conv_req_o  (conv_req_o),
        .conv_ch_o   (conv_ch_o),
        .conv_done_o (conv_done_o),
        .seq_done_o  (seq_done_o),
        .sel_err_o   (sel_err_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic exp_dual(input logic en, input logic sh, input logic [3:0] sel);
        return en && sh && (sel >= 4'd12);
    endfunction

    function automatic logic exp_bad(input logic en, input logic sh, input logic [3:0] sel);
        return en && sh && (sel < 4'd12);
    endfunction

    function automatic logic [7:0] exp_rd(input logic st);
        return {m_sel, 2'b00, st, m_en};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en_i = 1'b0; wr_data_i = '0; start_i = 1'b0;
        sh_mode_i = 1'b0; prim_ch_i = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_en = 1'b0; m_sel = '0; m_err = 1'b0;
    endtask

    task automatic bus_write(input logic [7:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_data_i = d;
        @(posedge clk);
        @(negedge clk);
        wr_en_i = 1'b0;
        m_en = d[0]; m_sel = d[7:4];
        chk("R2 readback", rd_data_o, exp_rd(1'b0));
    endtask

    // disturb: write en=1,sel=0 and pulse start during the first phase (R9, R3)
    // same_wr: write 8'h00 in the same cycle as the start (R9)
    task automatic run_seq(input logic [3:0] prim, input logic sh,
                           input logic disturb, input logic same_wr);
        logic dual;
        int   total;
        @(negedge clk);
        sh_mode_i = sh; prim_ch_i = prim; start_i = 1'b1;
        if (same_wr) begin
            wr_en_i = 1'b1; wr_data_i = 8'h00;
        end
        dual  = exp_dual(m_en, sh, m_sel);
        if (exp_bad(m_en, sh, m_sel)) m_err = 1'b1;
        total = dual ? 2*NCYC : NCYC;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        if (same_wr) begin
            wr_en_i = 1'b0; m_en = 1'b0; m_sel = '0;
        end
        prim_ch_i = ~prim;   // sampled value must be kept
        for (int c = 1; c <= total + 2; c++) begin
            logic st;
            st = dual && (c > NCYC) && (c <= 2*NCYC);
            chk("R3 request", conv_req_o, (c <= total));
            if (c <= total) chk("R3/R5 channel", conv_ch_o, (c <= NCYC) ? prim : m_sel_snap(dual));
            chk("R6 status", rd_data_o[1], st);
            chk("R4 done", conv_done_o, (c == NCYC + 1) || (dual && c == 2*NCYC + 1));
            chk("R4 complete", seq_done_o, (c == total + 1));
            chk("R8 error", sel_err_o, m_err);
            if (disturb && c == 2) begin
                wr_en_i = 1'b1; wr_data_i = 8'h01; start_i = 1'b1;
            end
            if (disturb && c == 3) begin
                wr_en_i = 1'b0; start_i = 1'b0;
                m_en = 1'b1; m_sel = 4'd0;
                chk("R9 write visible", rd_data_o, exp_rd(1'b0));
            end
            @(negedge clk);
        end
    endtask

    // the secondary channel latched at start; kept in a bench variable
    logic [3:0] snap_sel;
    function automatic logic [3:0] m_sel_snap(input logic d);
        return d ? snap_sel : 4'd0;
    endfunction

    task automatic run(input logic [3:0] prim, input logic sh,
                       input logic disturb, input logic same_wr);
        snap_sel = m_sel;
        run_seq(prim, sh, disturb, same_wr);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int unused;
        unused = $urandom(32'd1234);
        rst = 1'b1; wr_en_i = 1'b0; wr_data_i = '0; start_i = 1'b0;
        sh_mode_i = 1'b0; prim_ch_i = '0;
        m_en = 1'b0; m_sel = '0; m_err = 1'b0;
        do_reset();

        // R1: reset state
        chk("R1 reg", rd_data_o, 8'h00);
        chk("R1 req", conv_req_o, 1'b0);
        chk("R1 done", conv_done_o, 1'b0);
        chk("R1 complete", seq_done_o, 1'b0);
        chk("R1 err", sel_err_o, 1'b0);

        // R2: reserved bits and status bit ignore writes
        bus_write(8'hFF);
        chk("R2 reserved/status", rd_data_o[3:1], 3'b000);

        // R5/R6: legal pair, lowest legal code
        bus_write(8'hC1);
        run(4'd3, 1'b1, 1'b0, 1'b0);
        // R5: highest code
        bus_write(8'hF1);
        run(4'd7, 1'b1, 1'b0, 1'b0);
        // R7: mode masked, illegal code gives no error
        bus_write(8'h21);
        run(4'd1, 1'b0, 1'b0, 1'b0);
        // R10: enable clear with legal and illegal codes
        bus_write(8'hD0);
        run(4'd2, 1'b1, 1'b0, 1'b0);
        bus_write(8'h00);
        run(4'd4, 1'b1, 1'b0, 1'b0);
        // R9: write in the same cycle as start does not apply to that start
        bus_write(8'hE1);
        run(4'd6, 1'b1, 1'b0, 1'b1);
        chk("R9 same-cycle write landed", rd_data_o, 8'h00);
        // R9/R3: write and start during a pair; then boundary code 4'b1011 errors (R8)
        bus_write(8'hD1);
        run(4'd5, 1'b1, 1'b1, 1'b0);
        bus_write(8'hB1);
        run(4'd9, 1'b1, 1'b0, 1'b0);
        // R8: error stays across a later clean pair
        bus_write(8'hC1);
        run(4'd8, 1'b1, 1'b0, 1'b0);
        chk("R8 sticky", sel_err_o, 1'b1);

        // R1: reset clears the error
        do_reset();
        chk("R1 err cleared", sel_err_o, 1'b0);

        // random mix
        for (int i = 0; i < 60; i++) begin
            logic [7:0] d;
            d = 8'($urandom);
            if (i % 3 == 0) d[7:6] = 2'b11;
            bus_write(d);
            run(4'($urandom), 1'($urandom), 1'b0, 1'b0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule